// File: doc/BRIEF.md
# Vector Integer Instruction Decoder

This block turns a 32-bit instruction word into the control fields that a vector integer pipeline needs. It recognises the vector major opcode and one of three operand forms: two vector sources, a vector and a scalar register, or a vector and a 5-bit immediate. It then looks up a 6-bit function code and returns an internal operation number. It also reports whether the operation is legal in the requested form, passes the register indices and the mask bit through, and extends the immediate to the full datapath width.

Words enter on a valid/ready channel, and each accepted word produces one result on an output valid/ready channel one cycle later. The decoder holds a single result register. When the consumer holds `out_ready` low while a result is pending, `in_ready` drops and the result stays frozen until the consumer takes it. When a new word arrives in the same cycle that the pending result is taken, the new result replaces it with no bubble.

Top module: `vdec_top`

## Requirements
- R1: A word is legal only if bits [6:0] equal 1010111. Any other value gives `out_legal` = 0.
- R2: Bits [14:12] select the form. 000 gives vector-vector and `out_kind` 1. 100 gives vector-scalar and `out_kind` 2. 011 gives vector-immediate and `out_kind` 3. Every other value is illegal.
- R3: Bits [31:26] map to `out_op` as follows: 000000→1 add, 000010→2 sub, 000011→3 reverse-sub, 001001→4 and, 001010→5 or, 001011→6 xor, 100101→7 shift-left, 101000→8 logical shift-right, 101001→9 arithmetic shift-right, 000100→10 min-unsigned, 000101→11 min, 000110→12 max-unsigned, 000111→13 max, 011000→14 set-equal, 011001→15 set-not-equal, 011010→16 set-less-unsigned, 011011→17 set-less, 011100→18 set-less-equal-unsigned, 011101→19 set-less-equal, 011110→20 set-greater-unsigned, 011111→21 set-greater. Any other code is illegal.
- R4: Each operation is legal only in its allowed forms. Sub, min, max, min-unsigned, max-unsigned, set-less and set-less-unsigned allow vector-vector and vector-scalar. Reverse-sub, set-greater and set-greater-unsigned allow vector-scalar and immediate. All other operations allow all three forms.
- R5: When a result is illegal, `out_op`, `out_kind`, `out_vd`, `out_vs2`, `out_vs1`, `out_vm` and `out_imm` are all zero.
- R6: A legal result carries `out_vd` = bits [11:7], `out_vs2` = bits [24:20], `out_vs1` = bits [19:15] (vector or scalar source) and `out_vm` = bit 25 (1 unmasked, 0 masked), over the full range 0 to 31.
- R7: In the immediate form, except for the three shifts, `out_imm` is bits [19:15] sign-extended to 64 bits (11111 gives -1, 10000 gives -16).
- R8: In the immediate form of the three shifts, `out_imm` is bits [19:15] zero-extended (11111 gives 31).
- R9: A legal vector-vector or vector-scalar result has `out_imm` = 0.
- R10: `out_valid` rises in the cycle after a word is accepted. Synchronous reset clears `out_valid` and `out_legal`.
- R11: `in_ready` = !`out_valid` | `out_ready`. While `out_valid` is high and `out_ready` is low, every output field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_legal | output | 1 | Encoding is legal |
| out_op | output | 5 | Operation number |
| out_kind | output | 2 | Form: 1 vector-vector, 2 vector-scalar, 3 immediate |
| out_vd | output | 5 | Destination register |
| out_vs2 | output | 5 | First vector source |
| out_vs1 | output | 5 | Second source (vector or scalar) |
| out_vm | output | 1 | Mask bit, 1 = unmasked |
| out_imm | output | XLEN (64) | Extended immediate |

## Verification
The bench builds the decoder with the default XLEN of 64, so that the sign and zero extension of the immediate are checked at full width. It sweeps every function code against every form code and both mask values, and it uses register patterns that include the extreme indices. It also sweeps all 32 immediate values through a sign-extending operation and through each shift. Corrupted major opcodes and a stalled consumer complete the coverage, including a new word that waits behind a held result.

// File: rtl/vdec_pkg.sv
package vdec_pkg;
  localparam int OP_W   = 5;
  localparam int KIND_W = 2;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 5;
  localparam logic [6:0] MAJOR_VEC = 7'b1010111;

  typedef enum logic [KIND_W-1:0] {
    K_NONE = 2'd0, K_VV = 2'd1, K_VX = 2'd2, K_VI = 2'd3
  } kind_e;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 5'd0,  OP_ADD = 5'd1,  OP_SUB = 5'd2,  OP_RSUB = 5'd3,
    OP_AND  = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_SLL  = 5'd7,
    OP_SRL  = 5'd8,  OP_SRA = 5'd9,  OP_MINU = 5'd10, OP_MIN = 5'd11,
    OP_MAXU = 5'd12, OP_MAX = 5'd13, OP_SEQ = 5'd14, OP_SNE = 5'd15,
    OP_SLTU = 5'd16, OP_SLT = 5'd17, OP_SLEU = 5'd18, OP_SLE = 5'd19,
    OP_SGTU = 5'd20, OP_SGT = 5'd21
  } op_e;

  // form mask bits: [0] vector-vector, [1] vector-scalar, [2] immediate
  localparam logic [2:0] FM_ALL  = 3'b111;
  localparam logic [2:0] FM_VVVX = 3'b011;
  localparam logic [2:0] FM_VXVI = 3'b110;
endpackage

// File: rtl/vdec_opmap.sv
module vdec_opmap
  import vdec_pkg::*;
(
  input  logic [5:0] funct6,
  output op_e        op,
  output logic [2:0] forms,
  output logic       is_shift
);
  always_comb begin
    op    = OP_NONE;
    forms = 3'b000;
    unique case (funct6)
      6'b000000: begin op = OP_ADD;  forms = FM_ALL;  end
      6'b000010: begin op = OP_SUB;  forms = FM_VVVX; end
      6'b000011: begin op = OP_RSUB; forms = FM_VXVI; end
      6'b001001: begin op = OP_AND;  forms = FM_ALL;  end
      6'b001010: begin op = OP_OR;   forms = FM_ALL;  end
      6'b001011: begin op = OP_XOR;  forms = FM_ALL;  end
      6'b100101: begin op = OP_SLL;  forms = FM_ALL;  end
      6'b101000: begin op = OP_SRL;  forms = FM_ALL;  end
      6'b101001: begin op = OP_SRA;  forms = FM_ALL;  end
      6'b000100: begin op = OP_MINU; forms = FM_VVVX; end
      6'b000101: begin op = OP_MIN;  forms = FM_VVVX; end
      6'b000110: begin op = OP_MAXU; forms = FM_VVVX; end
      6'b000111: begin op = OP_MAX;  forms = FM_VVVX; end
      6'b011000: begin op = OP_SEQ;  forms = FM_ALL;  end
      6'b011001: begin op = OP_SNE;  forms = FM_ALL;  end
      6'b011010: begin op = OP_SLTU; forms = FM_VVVX; end
      6'b011011: begin op = OP_SLT;  forms = FM_VVVX; end
      6'b011100: begin op = OP_SLEU; forms = FM_ALL;  end
      6'b011101: begin op = OP_SLE;  forms = FM_ALL;  end
      6'b011110: begin op = OP_SGTU; forms = FM_VXVI; end
      6'b011111: begin op = OP_SGT;  forms = FM_VXVI; end
      default:   begin op = OP_NONE; forms = 3'b000;  end
    endcase
  end

  assign is_shift = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
endmodule

// File: rtl/vdec_form.sv
module vdec_form
  import vdec_pkg::*;
(
  input  logic [2:0] funct3,
  output kind_e      kind,
  output logic [2:0] sel
);
  always_comb begin
    unique case (funct3)
      3'b000:  begin kind = K_VV;   sel = 3'b001; end
      3'b100:  begin kind = K_VX;   sel = 3'b010; end
      3'b011:  begin kind = K_VI;   sel = 3'b100; end
      default: begin kind = K_NONE; sel = 3'b000; end
    endcase
  end
endmodule

// File: rtl/vdec_immext.sv
module vdec_immext
  import vdec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [IMM_W-1:0] raw,
  input  logic             zext,
  output logic [XLEN-1:0]  imm
);
  localparam int FILL_W = XLEN - IMM_W;
  logic fill;
  assign fill = zext ? 1'b0 : raw[IMM_W-1];

  generate
    if (FILL_W > 0) begin : g_wide
      assign imm = {{FILL_W{fill}}, raw};
    end else begin : g_narrow
      assign imm = raw[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/vdec_top.sv
module vdec_top
  import vdec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_legal,
  output logic [4:0]      out_op,
  output logic [1:0]      out_kind,
  output logic [4:0]      out_vd,
  output logic [4:0]      out_vs2,
  output logic [4:0]      out_vs1,
  output logic            out_vm,
  output logic [XLEN-1:0] out_imm
);
  op_e             op;
  kind_e           kind;
  logic [2:0]      forms, sel;
  logic            is_shift, legal;
  logic [XLEN-1:0] imm_ext;

  vdec_opmap u_map (.funct6(in_word[31:26]), .op(op), .forms(forms), .is_shift(is_shift));
  vdec_form  u_frm (.funct3(in_word[14:12]), .kind(kind), .sel(sel));
  vdec_immext #(.XLEN(XLEN)) u_imm (.raw(in_word[19:15]), .zext(is_shift), .imm(imm_ext));

  assign legal = (in_word[6:0] == MAJOR_VEC) && (op != OP_NONE) && (|(sel & forms));

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_legal <= 1'b0;
      out_op    <= '0;
      out_kind  <= '0;
      out_vd    <= '0;
      out_vs2   <= '0;
      out_vs1   <= '0;
      out_vm    <= 1'b0;
      out_imm   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_legal <= legal;
      out_op    <= legal ? op : OP_NONE;
      out_kind  <= legal ? kind : K_NONE;
      out_vd    <= legal ? in_word[11:7]  : '0;
      out_vs2   <= legal ? in_word[24:20] : '0;
      out_vs1   <= legal ? in_word[19:15] : '0;
      out_vm    <= legal && in_word[25];
      out_imm   <= (legal && kind == K_VI) ? imm_ext : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vdec_chk.sv
module vdec_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     in_word,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_legal,
  input logic [4:0]      out_op,
  input logic [1:0]      out_kind,
  input logic [4:0]      out_vd,
  input logic [XLEN-1:0] out_imm
);
  // R10
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R1
  bad_major_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_word[6:0] != 7'b1010111) |=> !out_legal);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_imm)
                                   && $stable(out_legal) && $stable(out_vd)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R5
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_legal) |-> (out_op == '0 && out_kind == '0 && out_imm == '0));

  // R9
  no_imm_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_legal && out_kind != 2'd3) |-> (out_imm == '0));
endmodule

bind vdec_top vdec_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
  .out_valid(out_valid), .out_ready(out_ready), .out_legal(out_legal), .out_op(out_op),
  .out_kind(out_kind), .out_vd(out_vd), .out_imm(out_imm)
);

// File: tb/sim_vdec_top.sv
module sim_vdec_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_legal;
  logic [4:0]  out_op;
  logic [1:0]  out_kind;
  logic [4:0]  out_vd, out_vs2, out_vs1;
  logic        out_vm;
  logic [63:0] out_imm;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vdec_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_legal(out_legal), .out_op(out_op),
    .out_kind(out_kind), .out_vd(out_vd), .out_vs2(out_vs2), .out_vs1(out_vs1),
    .out_vm(out_vm), .out_imm(out_imm)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h word=%h", tag, act, exp, in_word);
    end
  endtask

  function automatic logic [4:0] ref_op(input logic [5:0] f);
    case (f)
      6'b000000: return 5'd1;  6'b000010: return 5'd2;  6'b000011: return 5'd3;
      6'b001001: return 5'd4;  6'b001010: return 5'd5;  6'b001011: return 5'd6;
      6'b100101: return 5'd7;  6'b101000: return 5'd8;  6'b101001: return 5'd9;
      6'b000100: return 5'd10; 6'b000101: return 5'd11; 6'b000110: return 5'd12;
      6'b000111: return 5'd13; 6'b011000: return 5'd14; 6'b011001: return 5'd15;
      6'b011010: return 5'd16; 6'b011011: return 5'd17; 6'b011100: return 5'd18;
      6'b011101: return 5'd19; 6'b011110: return 5'd20; 6'b011111: return 5'd21;
      default:   return 5'd0;
    endcase
  endfunction

  // bit k-1 set when form k (1 vv, 2 vx, 3 vi) is allowed
  function automatic logic [2:0] ref_forms(input logic [4:0] op);
    case (op)
      5'd2, 5'd10, 5'd11, 5'd12, 5'd13, 5'd16, 5'd17: return 3'b011;
      5'd3, 5'd20, 5'd21:                             return 3'b110;
      5'd0:                                           return 3'b000;
      default:                                        return 3'b111;
    endcase
  endfunction

  task automatic run(input logic [31:0] w);
    logic [4:0]  eop;
    logic [1:0]  k;
    logic        leg;
    logic [63:0] eimm;
    logic [2:0]  fm;
    string       why;
    eop = ref_op(w[31:26]);
    case (w[14:12])
      3'b000: k = 2'd1;
      3'b100: k = 2'd2;
      3'b011: k = 2'd3;
      default: k = 2'd0;
    endcase
    fm  = ref_forms(eop);
    leg = (w[6:0] == 7'b1010111) && (k != 0) && (eop != 0) && fm[k-1];
    if (w[6:0] != 7'b1010111) why = "R1";
    else if (k == 0) why = "R2";
    else if (eop == 0) why = "R3";
    else why = "R4";
    eimm = 64'd0;
    if (leg && k == 2'd3) begin
      if (eop >= 5'd7 && eop <= 5'd9) eimm = {59'd0, w[19:15]};
      else eimm = {{59{w[19]}}, w[19:15]};
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 valid", {63'd0, out_valid}, 64'd1);
    chk(why, {63'd0, out_legal}, {63'd0, leg});
    if (leg) begin
      chk("R3 op", {59'd0, out_op}, {59'd0, eop});
      chk("R2 kind", {62'd0, out_kind}, {62'd0, k});
      chk("R6 regs", {48'd0, out_vd, out_vs2, out_vs1, out_vm},
          {48'd0, w[11:7], w[24:20], w[19:15], w[25]});
      if (k == 2'd3 && eop >= 5'd7 && eop <= 5'd9) chk("R8 imm", out_imm, eimm);
      else if (k == 2'd3) chk("R7 imm", out_imm, eimm);
      else chk("R9 imm", out_imm, eimm);
    end else begin
      chk("R5 zero", {out_imm[47:0], 5'd0, out_op, out_kind, out_vd, out_vs2} ^
          {48'd0, 5'd0, 10'd0, out_vs1, out_vm}, 64'd0);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm, input logic [4:0] a,
                                     input logic [4:0] b, input logic [2:0] f3, input logic [4:0] d);
    return {f6, vm, a, b, f3, d, 7'b1010111};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R10 reset legal", {63'd0, out_legal}, 64'd0);
    chk("R11 ready idle", {63'd0, in_ready}, 64'd1);

    for (int f6 = 0; f6 < 64; f6++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int vm = 0; vm < 2; vm++) begin
          run(mk(6'(f6), 1'(vm), 5'd2, 5'd3, 3'(f3), 5'd1));
          run(mk(6'(f6), 1'(vm), 5'd31, 5'd31, 3'(f3), 5'd31));
          run(mk(6'(f6), 1'(vm), 5'd16, 5'd16, 3'(f3), 5'd0));
        end

    // R7 R8 full immediate sweep
    for (int v = 0; v < 32; v++) begin
      run(mk(6'b000000, 1'b1, 5'd4, 5'(v), 3'b011, 5'd2));
      run(mk(6'b100101, 1'b1, 5'd4, 5'(v), 3'b011, 5'd2));
      run(mk(6'b101000, 1'b0, 5'd4, 5'(v), 3'b011, 5'd2));
      run(mk(6'b101001, 1'b1, 5'd4, 5'(v), 3'b011, 5'd2));
      run(mk(6'b011101, 1'b1, 5'd4, 5'(v), 3'b011, 5'd2));
    end

    // R1 wrong major opcodes
    for (int o = 0; o < 128; o++)
      if (o != 7'b1010111) run({6'b000000, 1'b1, 5'd2, 5'd3, 3'b000, 5'd1, 7'(o)});

    // R11 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_word   = mk(6'b000011, 1'b1, 5'd7, 5'b11110, 3'b011, 5'd9);
    @(negedge clk);
    in_word = mk(6'b001001, 1'b0, 5'd1, 5'd5, 3'b100, 5'd6);
    for (int c = 0; c < 3; c++) begin
      chk("R11 blocked", {63'd0, in_ready}, 64'd0);
      chk("R11 hold op", {59'd0, out_op}, 64'd3);
      chk("R11 hold imm", out_imm, 64'hFFFF_FFFF_FFFF_FFFE);
      chk("R11 hold vd", {59'd0, out_vd}, 64'd9);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 next op", {59'd0, out_op}, 64'd4);
    chk("R11 next vd", {59'd0, out_vd}, 64'd6);
    chk("R11 next kind", {62'd0, out_kind}, 64'd2);
    @(negedge clk);
    chk("R10 drain", {63'd0, out_valid}, 64'd0);

    // R10 reset clears a pending result
    in_valid = 1'b1;
    in_word  = mk(6'b000000, 1'b1, 5'd2, 5'd3, 3'b000, 5'd1);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset clears valid", {63'd0, out_valid}, 64'd0);
    chk("R10 reset clears legal", {63'd0, out_legal}, 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule